// File: doc/BRIEF.md
# Group-Aware Interrupt Signalling Arbiter

This block serves one processor. It looks at every interrupt line that is pending and enabled, picks the one with the best (numerically lowest) priority, and signals it to the processor on one of two wires. One wire is the normal interrupt request. The other is a fast request. Each line is tagged as group 0 (secure) or group 1 (non-secure). The group tag, the group enables held in the global and per-processor control words, and a fast-request enable decide which wire is raised, or whether either is raised.

The block also answers identification reads. A read is either a peek at the highest pending ID or an acknowledge. Depending on the security state of the access, it returns the winner's ID or a spurious code. Code 1023 means nothing is visible. Code 1022 means a group-1 winner is hidden from a secure reader.

The bus decode and the active-priority bookkeeping live outside the block. The running priority arrives as an input, with 0x100 meaning idle.

Top module: `irqsel_top`

## Requirements
- R1: When neither bit of `dist_grp_en` is effective, or neither of `cpu_ctl[1:0]` is effective, both outputs are low one cycle later and every read returns 1023.
- R2: The winner becomes the current pending ID only if its priority is strictly below `prio_mask`. It raises an output only if its priority is also strictly below `run_prio`. Otherwise a peek returns 1023.
- R3: An output is raised only if the winner's group is enabled in both `dist_grp_en` and `cpu_ctl`. Bit 0 of each enables group 0 and bit 1 enables group 1.
- R4: A group-0 winner raises `fiq_o` when `cpu_ctl[3]` is set, and raises `irq_o` otherwise. A group-1 winner always raises `irq_o`. The two outputs are never high together.
- R5: With grouping active, a non-secure read (`rd_secure`=0 while `cfg_sec_ext`=1) of a group-0 pending interrupt returns 1023.
- R6: With grouping active, a secure read of a group-1 pending interrupt returns 1022 unless `cpu_ctl[2]` is set, in which case it returns the ID.
- R7: When `cfg_sec_ext`=0, every read is treated as secure. When neither `cfg_rev2` nor `cfg_sec_ext` is set, grouping is off. In that case every line acts as group 0, and `dist_grp_en[1]`, `cpu_ctl[3:1]` and `irq_grp` have no effect.
- R8: An acknowledge (`rd_is_ack`=1) of a visible interrupt whose priority is not strictly below `run_prio` returns 1023. A peek of the same state returns the ID.
- R9: Among lines of equal best priority, the lowest line number wins.
- R10: `irq_o`, `fiq_o` and the pending state are registered and follow input changes one cycle later. A read issued with `rd_req` returns `rd_id` with `rd_valid` high one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sec_ext | input | 1 | Security extensions present |
| cfg_rev2 | input | 1 | Second-revision configuration (grouping always on) |
| dist_grp_en | input | 2 | Global group enables: bit 0 for group 0, bit 1 for group 1 |
| cpu_ctl | input | 4 | Processor control: bit 0 and bit 1 group enables, bit 2 acknowledge control, bit 3 fast-request enable |
| prio_mask | input | 8 | Processor priority mask |
| run_prio | input | 9 | Running priority; 0x100 means idle |
| irq_pend | input | NUM_IRQ | Pending flag per line |
| irq_en | input | NUM_IRQ | Enable flag per line |
| irq_grp | input | NUM_IRQ | Group per line (1 = group 1) |
| irq_prio | input | NUM_IRQ*8 | Priority per line, line n in bits [8n+7:8n] |
| rd_req | input | 1 | Read request |
| rd_is_ack | input | 1 | 1 = acknowledge, 0 = peek at highest pending |
| rd_secure | input | 1 | Security state of the read |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| rd_valid | output | 1 | Read data valid |
| rd_id | output | 10 | ID returned, or 1022/1023 |

## Verification
The hardest state to reach is one where the winner is current pending but not signalled. Its priority has to lie below the mask yet not below the running priority. That is the only state in which peek and acknowledge must disagree. The bench reaches it by holding a single line at priority 0x40, opening the mask to 0x41, and then lowering `run_prio` to exactly 0x40. It then issues one peek and one acknowledge against the same registered state. The hidden-group codes are reached by keeping the same line pending and flipping its group tag, `cpu_ctl[2]` and the read's security state in turn.

// File: rtl/irqsel_pkg.sv
// Package: shared constants for the group-aware interrupt arbiter.
// Assumes IDs fit in 10 bits and priorities in 8 bits.
package irqsel_pkg;
    localparam int          ID_W      = 10;
    localparam int          PRIO_W    = 8;
    localparam logic [9:0]  ID_NONE   = 10'd1023;
    localparam logic [9:0]  ID_HIDDEN = 10'd1022;
    localparam logic [8:0]  PRIO_IDLE = 9'h100;
endpackage

// File: rtl/irqsel_search.sv
// Module: combinational best-priority search over all interrupt lines.
// Assumes NUM_IRQ <= 1020. The search starts from the idle value 0x100 and
// takes a candidate only on a strictly better priority, so ties go to the
// lowest line number.
module irqsel_search
    import irqsel_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic [NUM_IRQ-1:0]        pend_i,
    input  logic [NUM_IRQ-1:0]        en_i,
    input  logic [NUM_IRQ-1:0]        grp_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
    output logic [ID_W-1:0]           best_id_o,
    output logic [PRIO_W:0]           best_prio_o,
    output logic                      best_grp_o
);
    logic [NUM_IRQ-1:0] elig;
    logic [PRIO_W-1:0]  prio_a [NUM_IRQ];

    // Per-line eligibility and priority unpacking
    generate
        for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
            assign elig[g]   = pend_i[g] & en_i[g];
            assign prio_a[g] = prio_i[g*PRIO_W +: PRIO_W];
        end
    endgenerate

    // Linear minimum search, strict compare keeps the lowest ID on ties
    always_comb begin
        best_prio_o = PRIO_IDLE;
        best_id_o   = ID_NONE;
        best_grp_o  = 1'b0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (elig[i] && ({1'b0, prio_a[i]} < best_prio_o)) begin
                best_prio_o = {1'b0, prio_a[i]};
                best_id_o   = ID_W'(i);
                best_grp_o  = grp_i[i];
            end
        end
    end
endmodule

// File: rtl/irqsel_route.sv
// Module: registers the current pending interrupt and routes it to the
// normal or fast request wire. Assumes the enables given are already
// reduced to their effective values for the configuration.
module irqsel_route
    import irqsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   best_id_i,
    input  logic [PRIO_W:0]   best_prio_i,
    input  logic              best_grp_i,
    input  logic [1:0]        dist_en_i,
    input  logic [3:0]        cpu_ctl_i,
    input  logic [PRIO_W-1:0] mask_i,
    input  logic [PRIO_W:0]   run_prio_i,
    output logic [ID_W-1:0]   cur_id_q,
    output logic [PRIO_W:0]   cur_prio_q,
    output logic              cur_grp_q,
    output logic              irq_q,
    output logic              fiq_q
);
    logic            any_en;
    logic [ID_W-1:0] nxt_id;
    logic [PRIO_W:0] nxt_prio;
    logic            nxt_grp, nxt_irq, nxt_fiq;

    assign any_en = (|dist_en_i) && (|cpu_ctl_i[1:0]);

    // Next pending state and output routing
    always_comb begin
        nxt_id   = ID_NONE;
        nxt_prio = PRIO_IDLE;
        nxt_grp  = 1'b0;
        nxt_irq  = 1'b0;
        nxt_fiq  = 1'b0;
        if (any_en && (best_prio_i < {1'b0, mask_i})) begin
            nxt_id   = best_id_i;
            nxt_prio = best_prio_i;
            nxt_grp  = best_grp_i;
            if ((best_prio_i < run_prio_i) && dist_en_i[best_grp_i]
                && cpu_ctl_i[best_grp_i]) begin
                if (!best_grp_i && cpu_ctl_i[3]) nxt_fiq = 1'b1;
                else                             nxt_irq = 1'b1;
            end
        end
    end

    // State register, synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_id_q   <= ID_NONE;
            cur_prio_q <= PRIO_IDLE;
            cur_grp_q  <= 1'b0;
            irq_q      <= 1'b0;
            fiq_q      <= 1'b0;
        end else begin
            cur_id_q   <= nxt_id;
            cur_prio_q <= nxt_prio;
            cur_grp_q  <= nxt_grp;
            irq_q      <= nxt_irq;
            fiq_q      <= nxt_fiq;
        end
    end

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !any_en |=> (!irq_q && !fiq_q && cur_id_q == ID_NONE)); // R1
    AST_OUT_HAS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q || fiq_q) |-> (cur_id_q != ID_NONE && cur_prio_q < {1'b0, $past(mask_i)})); // R2
    AST_FIQ_GRP0: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_q |-> (!cur_grp_q && !irq_q)); // R4
endmodule

// File: rtl/irqsel_ack.sv
// Module: answers peek and acknowledge reads from the registered pending
// state, hiding the winner from the wrong security state. Assumes the
// active-priority stack is updated elsewhere.
module irqsel_ack
    import irqsel_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            grouping_i,
    input  logic            sec_ext_i,
    input  logic            ack_ctl_i,
    input  logic [ID_W-1:0] cur_id_i,
    input  logic [PRIO_W:0] cur_prio_i,
    input  logic            cur_grp_i,
    input  logic [PRIO_W:0] run_prio_i,
    input  logic            rd_req_i,
    input  logic            rd_is_ack_i,
    input  logic            rd_secure_i,
    output logic            rd_valid_q,
    output logic [ID_W-1:0] rd_id_q
);
    logic            sec_view;
    logic [ID_W-1:0] ans;

    assign sec_view = !sec_ext_i || rd_secure_i;

    // Visibility filter and acknowledge priority check
    always_comb begin
        ans = cur_id_i;
        if (cur_id_i != ID_NONE) begin
            if (grouping_i && !cur_grp_i && !sec_view)
                ans = ID_NONE;
            else if (grouping_i && cur_grp_i && sec_view && !ack_ctl_i)
                ans = ID_HIDDEN;
            else if (rd_is_ack_i && (cur_prio_i >= run_prio_i))
                ans = ID_NONE;
        end
    end

    // Read response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_id_q    <= ID_NONE;
        end else begin
            rd_valid_q <= rd_req_i;
            if (rd_req_i) rd_id_q <= ans;
        end
    end

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_i |=> rd_valid_q); // R10
    AST_NS_GRP0_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && grouping_i && sec_ext_i && !rd_secure_i && !cur_grp_i)
        |=> (rd_id_q == ID_NONE)); // R5
    AST_ACK_LOW_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && rd_is_ack_i && cur_prio_i >= run_prio_i) |=> (rd_id_q >= ID_HIDDEN)); // R8
    AST_GRP1_SEC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && grouping_i && cur_grp_i && cur_id_i != ID_NONE && sec_view && !ack_ctl_i)
        |=> (rd_id_q == ID_HIDDEN)); // R6
endmodule

// File: rtl/irqsel_top.sv
// Module: top of the group-aware interrupt arbiter for one processor.
// Reduces the control bits to their effective values for the configuration,
// then chains search, routing and read filtering. Assumes stable cfg inputs.
module irqsel_top
    import irqsel_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_sec_ext,
    input  logic                      cfg_rev2,
    input  logic [1:0]                dist_grp_en,
    input  logic [3:0]                cpu_ctl,
    input  logic [PRIO_W-1:0]         prio_mask,
    input  logic [PRIO_W:0]           run_prio,
    input  logic [NUM_IRQ-1:0]        irq_pend,
    input  logic [NUM_IRQ-1:0]        irq_en,
    input  logic [NUM_IRQ-1:0]        irq_grp,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
    input  logic                      rd_req,
    input  logic                      rd_is_ack,
    input  logic                      rd_secure,
    output logic                      irq_o,
    output logic                      fiq_o,
    output logic                      rd_valid,
    output logic [ID_W-1:0]           rd_id
);
    logic                grouping;
    logic [1:0]          dist_eff;
    logic [3:0]          cpu_eff;
    logic [NUM_IRQ-1:0]  grp_eff;
    logic [ID_W-1:0]     best_id, cur_id;
    logic [PRIO_W:0]     best_prio, cur_prio;
    logic                best_grp, cur_grp;

    // Without grouping every line is group 0 and only bit 0 enables count
    assign grouping = cfg_rev2 || cfg_sec_ext;
    assign dist_eff = grouping ? dist_grp_en : {1'b0, dist_grp_en[0]};
    assign cpu_eff  = grouping ? cpu_ctl     : {3'b000, cpu_ctl[0]};
    assign grp_eff  = irq_grp & {NUM_IRQ{grouping}};

    irqsel_search #(.NUM_IRQ(NUM_IRQ)) u_search (
        .pend_i(irq_pend), .en_i(irq_en), .grp_i(grp_eff), .prio_i(irq_prio),
        .best_id_o(best_id), .best_prio_o(best_prio), .best_grp_o(best_grp)
    );

    irqsel_route u_route (
        .clk(clk), .rst_n(rst_n),
        .best_id_i(best_id), .best_prio_i(best_prio), .best_grp_i(best_grp),
        .dist_en_i(dist_eff), .cpu_ctl_i(cpu_eff), .mask_i(prio_mask),
        .run_prio_i(run_prio),
        .cur_id_q(cur_id), .cur_prio_q(cur_prio), .cur_grp_q(cur_grp),
        .irq_q(irq_o), .fiq_q(fiq_o)
    );

    irqsel_ack u_ack (
        .clk(clk), .rst_n(rst_n),
        .grouping_i(grouping), .sec_ext_i(cfg_sec_ext), .ack_ctl_i(cpu_eff[2]),
        .cur_id_i(cur_id), .cur_prio_i(cur_prio), .cur_grp_i(cur_grp),
        .run_prio_i(run_prio),
        .rd_req_i(rd_req), .rd_is_ack_i(rd_is_ack), .rd_secure_i(rd_secure),
        .rd_valid_q(rd_valid), .rd_id_q(rd_id)
    );

    AST_NO_GROUPING_IRQ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rev2 && !cfg_sec_ext && $past(!cfg_rev2 && !cfg_sec_ext)) |-> !fiq_o); // R7
endmodule

// File: tb/test_irqsel_top.sv
module test_irqsel_top;
    localparam int N = 32;

    logic clk = 1'b0;
    logic rst_n;
    logic cfg_sec_ext, cfg_rev2;
    logic [1:0] dist_grp_en;
    logic [3:0] cpu_ctl;
    logic [7:0] prio_mask;
    logic [8:0] run_prio;
    logic [N-1:0] irq_pend, irq_en, irq_grp;
    logic [N*8-1:0] irq_prio;
    logic rd_req, rd_is_ack, rd_secure;
    logic irq_o, fiq_o, rd_valid;
    logic [9:0] rd_id;

    int n_tests = 0;
    int n_fail  = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irqsel_top #(.NUM_IRQ(N)) i_irqsel_top (.*);

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Let registered state follow the inputs driven at this negedge
    task automatic settle();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic rd(input logic ack, input logic sec, output logic [9:0] id);
        rd_req = 1'b1; rd_is_ack = ack; rd_secure = sec;
        @(negedge clk);
        id = rd_id;
        check("R10 rd_valid", int'(rd_valid), 1);
        rd_req = 1'b0;
    endtask

    task automatic line(input int n, input logic g, input logic [7:0] p);
        irq_pend[n] = 1'b1; irq_en[n] = 1'b1; irq_grp[n] = g;
        irq_prio[n*8 +: 8] = p;
    endtask

    task automatic clear_lines();
        irq_pend = '0; irq_en = '0; irq_grp = '0; irq_prio = '1;
    endtask

    task automatic t_reset();
        logic [9:0] id;
        check("R10 reset irq", int'(irq_o), 0);
        check("R10 reset fiq", int'(fiq_o), 0);
        check("R10 reset rd_valid", int'(rd_valid), 0);
        rd(1'b0, 1'b1, id);
        check("R1 idle peek", int'(id), 1023);
    endtask

    task automatic t_disabled();
        logic [9:0] id;
        cfg_sec_ext = 0; cfg_rev2 = 1; clear_lines(); line(5, 1'b1, 8'h10);
        dist_grp_en = 2'b00; cpu_ctl = 4'b0111; settle();
        check("R1 dist off irq", int'(irq_o), 0);
        rd(1'b0, 1'b1, id);
        check("R1 dist off peek", int'(id), 1023);
        dist_grp_en = 2'b11; cpu_ctl = 4'b0100; settle();
        check("R1 cpu off irq", int'(irq_o), 0);
        check("R1 cpu off fiq", int'(fiq_o), 0);
    endtask

    task automatic t_mask_run();
        logic [9:0] id;
        cfg_sec_ext = 0; cfg_rev2 = 1; clear_lines(); line(5, 1'b1, 8'h40);
        dist_grp_en = 2'b11; cpu_ctl = 4'b0111; prio_mask = 8'h40; run_prio = 9'h100;
        settle();
        check("R2 mask equal irq", int'(irq_o), 0);
        rd(1'b0, 1'b1, id);
        check("R2 mask equal peek", int'(id), 1023);
        prio_mask = 8'h41;
        #1 check("R10 no change before edge", int'(irq_o), 0);
        settle();
        check("R2 R10 below mask irq", int'(irq_o), 1);
        rd(1'b0, 1'b1, id);
        check("R2 below mask peek", int'(id), 5);
        run_prio = 9'h040; settle();
        check("R2 run equal irq", int'(irq_o), 0);
        rd(1'b0, 1'b1, id);
        check("R8 peek still id", int'(id), 5);
        rd(1'b1, 1'b1, id);
        check("R8 ack low prio", int'(id), 1023);
        run_prio = 9'h041; settle();
        rd(1'b1, 1'b1, id);
        check("R8 ack ok", int'(id), 5);
        run_prio = 9'h100;
    endtask

    task automatic t_group_en();
        cfg_sec_ext = 0; cfg_rev2 = 1; clear_lines(); line(6, 1'b1, 8'h20);
        prio_mask = 8'hff; run_prio = 9'h100;
        dist_grp_en = 2'b01; cpu_ctl = 4'b0011; settle();
        check("R3 dist g1 off", int'(irq_o), 0);
        dist_grp_en = 2'b11; cpu_ctl = 4'b0001; settle();
        check("R3 cpu g1 off", int'(irq_o), 0);
        cpu_ctl = 4'b0011; settle();
        check("R3 both g1 on", int'(irq_o), 1);
    endtask

    task automatic t_fiq();
        cfg_sec_ext = 0; cfg_rev2 = 1; clear_lines(); line(3, 1'b0, 8'h20);
        dist_grp_en = 2'b11; cpu_ctl = 4'b1011; settle();
        check("R4 g0 fiq", int'(fiq_o), 1);
        check("R4 g0 fiq irq low", int'(irq_o), 0);
        cpu_ctl = 4'b0011; settle();
        check("R4 g0 irq", int'(irq_o), 1);
        check("R4 g0 fiq low", int'(fiq_o), 0);
        irq_grp[3] = 1'b1; cpu_ctl = 4'b1111; settle();
        check("R4 g1 irq despite fiq en", int'(irq_o), 1);
        check("R4 g1 no fiq", int'(fiq_o), 0);
    endtask

    task automatic t_tie();
        logic [9:0] id;
        cfg_sec_ext = 0; cfg_rev2 = 1; clear_lines();
        line(7, 1'b0, 8'h30); line(4, 1'b0, 8'h30); line(2, 1'b0, 8'h50);
        dist_grp_en = 2'b11; cpu_ctl = 4'b0011; settle();
        rd(1'b0, 1'b1, id);
        check("R9 tie lowest id", int'(id), 4);
        irq_en[4] = 1'b0; settle();
        rd(1'b0, 1'b1, id);
        check("R9 next of tie", int'(id), 7);
    endtask

    task automatic t_secure();
        logic [9:0] id;
        cfg_sec_ext = 1; cfg_rev2 = 0; clear_lines(); line(9, 1'b0, 8'h10);
        dist_grp_en = 2'b11; cpu_ctl = 4'b0011; settle();
        rd(1'b0, 1'b0, id);
        check("R5 ns peek g0", int'(id), 1023);
        rd(1'b1, 1'b0, id);
        check("R5 ns ack g0", int'(id), 1023);
        rd(1'b0, 1'b1, id);
        check("R5 s peek g0", int'(id), 9);
        irq_grp[9] = 1'b1; settle();
        rd(1'b0, 1'b1, id);
        check("R6 s peek g1 no ackctl", int'(id), 1022);
        rd(1'b0, 1'b0, id);
        check("R6 ns peek g1", int'(id), 9);
        cpu_ctl = 4'b0111; settle();
        rd(1'b1, 1'b1, id);
        check("R6 s ack g1 ackctl", int'(id), 9);
    endtask

    task automatic t_nosec();
        logic [9:0] id;
        cfg_sec_ext = 0; cfg_rev2 = 1; clear_lines(); line(9, 1'b0, 8'h10);
        dist_grp_en = 2'b11; cpu_ctl = 4'b0011; settle();
        rd(1'b0, 1'b0, id);
        check("R7 no sec ext acts secure", int'(id), 9);
        cfg_rev2 = 0; irq_grp[9] = 1'b1; dist_grp_en = 2'b01; cpu_ctl = 4'b1001;
        settle();
        check("R7 no grouping irq", int'(irq_o), 1);
        check("R7 no grouping fiq bit ignored", int'(fiq_o), 0);
        rd(1'b0, 1'b1, id);
        check("R7 no grouping no 1022", int'(id), 9);
        dist_grp_en = 2'b10; cpu_ctl = 4'b0011; settle();
        check("R7 bit1 enable ignored", int'(irq_o), 0);
    endtask

    initial begin
        rst_n = 0; cfg_sec_ext = 0; cfg_rev2 = 1; dist_grp_en = 0; cpu_ctl = 0;
        prio_mask = 8'hff; run_prio = 9'h100; rd_req = 0; rd_is_ack = 0;
        rd_secure = 1; clear_lines();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_mask_run();
        t_group_en();
        t_fiq();
        t_tie();
        t_secure();
        t_nosec();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule